// File: doc/BRIEF.md
# Receive Frame Accept Arbiter

This block makes the keep-or-drop decision for each received frame. It starts a frame when the delimiter-detected pulse arrives and the controller is running. It then counts byte strobes and waits for one of two events: the frame ends, or the byte count reaches the end of the external-reject window. At that point it combines four things into a single decision:

- the internal station-address match flag,
- a width-qualified active-low external reject line,
- promiscuous mode,
- the short-frame acceptance option.

A separate option disables the internal physical match when the logical filter is all zero, so that only the external line can decide.

A frame-side controller consumes the result. It arrives as a one-cycle `dec_valid` pulse with an `dec_accept` bit. The state machine has three states:

- IDLE: no frame is in progress.
- COLLECT: the reject window is open. The block records any internal match and any qualified reject.
- WAIT_EOF: the window has closed and the decision has been issued. The block waits for the end of the frame.

The transitions are:

- IDLE→COLLECT on a delimiter pulse while started.
- COLLECT→IDLE on end of frame, which issues the decision.
- COLLECT→WAIT_EOF on the window-closing byte, which issues the decision.
- WAIT_EOF→IDLE on end of frame.
- Any state→IDLE when the started input drops. No decision is issued in that case.

Top module: `rx_accept_arbiter`

## Requirements
- R1: A frame opens only on `sfd` while `started` is high. While `started` is low, or if it drops during a frame, no decision pulse is issued for that frame.
- R2: Each frame yields exactly one `dec_valid` pulse, one cycle wide. It appears in the cycle after the decision point.
- R3: When `int_match` is seen high at any cycle of the frame up to the decision point, and the match is not disabled by R9, the frame is accepted whatever `ext_reject_n` does.
- R4: With `cfg_prom` high, every frame not dropped by R8 is accepted, with no requirement on `ext_reject_n`.
- R5: A reject counts only after `ext_reject_n` has been sampled low on MIN_LOW consecutive clock edges. MIN_LOW is 200 ns rounded up to whole clock periods, which is 50 at 4 ns. A low run of MIN_LOW-1 edges has no effect.
- R6: A reject that qualifies after the window has closed is ignored. The window closes at the WINDOW_BYTES-th byte strobe (64 by default) after `sfd`.
- R7: A frame with no qualified reject inside its window is accepted. Long frames are decided at the window-closing strobe and short frames at `eof`.
- R8: An `eof` arriving before the window closes marks a short frame. With `cfg_runt_ok` low such a frame is always rejected. With it high, the normal rules apply.
- R9: When `cfg_no_phys` and `cfg_laf_zero` are both high, `int_match` is ignored. Only the external reject and promiscuous mode then decide.
- R10: During and after reset, `dec_valid` and `dec_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| started | input | 1 | Controller running; enables frame tracking |
| sfd | input | 1 | One-cycle pulse when the start delimiter is found |
| byte_stb | input | 1 | One-cycle pulse per received byte after the delimiter |
| eof | input | 1 | One-cycle pulse at end of frame |
| int_match | input | 1 | Internal physical or logical address match flag |
| ext_reject_n | input | 1 | External reject line, active low |
| cfg_prom | input | 1 | Promiscuous mode |
| cfg_runt_ok | input | 1 | Accept frames shorter than the window |
| cfg_no_phys | input | 1 | Disable internal physical match |
| cfg_laf_zero | input | 1 | Logical address filter is all zero |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision: 1 keep, 0 discard |

## Verification
The bench sweeps all 16 combinations of the four configuration bits. Each combination is crossed with the internal match present or absent, two frame lengths, and four patterns on the reject line:

- a quiet line,
- a low run one edge short of MIN_LOW,
- a qualifying low run inside the window,
- a qualifying low run after the window closes.

The short run separates R5 from a real reject, and the late run separates R6 from R7. The short frame length exposes the R8 rule under both option settings. Extra frames with `started` held low or dropped mid-frame check R1, and every frame's decision-pulse count checks R2.

// File: rtl/rx_accept_pkg.sv
package rx_accept_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COLLECT  = 2'd1,
        ST_WAIT_EOF = 2'd2
    } arb_state_t;
endpackage

// File: rtl/arb_low_width_qual.sv
// Counts consecutive low samples of an active-low line and flags the
// edge on which the run reaches MIN_LOW samples (and every edge after).
module arb_low_width_qual #(
    parameter int MIN_LOW = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic qualified
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_LOW - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (line_n) begin
            run_q <= '0;
        end else if (run_q != SAT) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Current low sample plus MIN_LOW-1 earlier consecutive lows
    assign qualified = !line_n && (run_q == SAT);
endmodule

// File: rtl/arb_byte_window.sv
// Byte-time counter started by the delimiter; flags the strobe that
// closes the external-reject window.
module arb_byte_window #(
    parameter int WINDOW_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic count_en,
    input  logic byte_stb,
    output logic close_now
);
    localparam int BW = $clog2(WINDOW_BYTES + 1);
    localparam logic [BW-1:0] LAST = BW'(WINDOW_BYTES - 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (count_en && byte_stb && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign close_now = count_en && byte_stb && (cnt_q == LAST);
endmodule

// File: rtl/rx_accept_arbiter.sv
module rx_accept_arbiter
    import rx_accept_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int MIN_PULSE_PS  = 200000,
    parameter int WINDOW_BYTES  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic started,
    input  logic sfd,
    input  logic byte_stb,
    input  logic eof,
    input  logic int_match,
    input  logic ext_reject_n,
    input  logic cfg_prom,
    input  logic cfg_runt_ok,
    input  logic cfg_no_phys,
    input  logic cfg_laf_zero,
    output logic dec_valid,
    output logic dec_accept
);
    localparam int MIN_LOW = (MIN_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    arb_state_t state_q, state_d;
    logic match_seen_q, rej_seen_q;
    logic rej_qual, win_close;
    logic match_now, rej_now, emit, accept_d;
    logic open_frame;

    arb_low_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_n    (ext_reject_n),
        .qualified (rej_qual)
    );

    assign open_frame = (state_q == ST_IDLE) && started && sfd;

    arb_byte_window #(.WINDOW_BYTES(WINDOW_BYTES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (open_frame),
        .count_en  (state_q == ST_COLLECT),
        .byte_stb  (byte_stb),
        .close_now (win_close)
    );

    // Effective internal match and qualified reject including this cycle
    assign match_now = (match_seen_q || int_match) && !(cfg_no_phys && cfg_laf_zero);
    assign rej_now   = rej_seen_q || rej_qual;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        emit     = 1'b0;
        accept_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (started && sfd) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (!started) begin
                    state_d = ST_IDLE;
                end else if (win_close) begin
                    state_d  = ST_WAIT_EOF;
                    emit     = 1'b1;
                    accept_d = cfg_prom || match_now || !rej_now;
                end else if (eof) begin
                    state_d  = ST_IDLE;
                    emit     = 1'b1;
                    accept_d = cfg_runt_ok && (cfg_prom || match_now || !rej_now);
                end
            end
            ST_WAIT_EOF: begin
                if (!started || eof) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and per-frame sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            match_seen_q <= 1'b0;
            rej_seen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (open_frame) begin
                match_seen_q <= 1'b0;
                rej_seen_q   <= 1'b0;
            end else if (state_q == ST_COLLECT) begin
                match_seen_q <= match_seen_q || int_match;
                rej_seen_q   <= rej_now;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= emit;
            dec_accept <= emit && accept_d;
        end
    end
endmodule

// File: rtl/rx_accept_arbiter_chk.sv
module rx_accept_arbiter_chk
    import rx_accept_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       started,
    input logic       eof,
    input logic       cfg_prom,
    input logic       cfg_runt_ok,
    input arb_state_t state_q,
    input logic       dec_valid,
    input logic       dec_accept
);
    // R2
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R2
    valid_from_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(state_q) == ST_COLLECT);

    // R1
    no_decision_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !started |=> !dec_valid);

    // R4
    prom_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_prom && cfg_runt_ok)) |-> dec_accept);

    // R8
    runt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(state_q == ST_COLLECT && eof && !cfg_runt_ok)) |-> !dec_accept);

    // R10
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);
endmodule

bind rx_accept_arbiter rx_accept_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .started     (started),
    .eof         (eof),
    .cfg_prom    (cfg_prom),
    .cfg_runt_ok (cfg_runt_ok),
    .state_q     (state_q),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept)
);

// File: tb/rx_accept_arbiter_bench.sv
module rx_accept_arbiter_bench;
    localparam int MIN_LOW = 50;
    localparam int WINDOW  = 64;
    localparam int BYTE_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic started = 1'b0, sfd = 1'b0, byte_stb = 1'b0, eof = 1'b0;
    logic int_match = 1'b0, ext_reject_n = 1'b1;
    logic cfg_prom = 1'b0, cfg_runt_ok = 1'b0, cfg_no_phys = 1'b0, cfg_laf_zero = 1'b0;
    logic dec_valid, dec_accept;

    int checks = 0;
    int fails  = 0;
    int n_valid = 0;
    logic last_acc = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_accept_arbiter u_rx_accept_arbiter (
        .clk(clk), .rst_n(rst_n), .started(started), .sfd(sfd),
        .byte_stb(byte_stb), .eof(eof), .int_match(int_match),
        .ext_reject_n(ext_reject_n), .cfg_prom(cfg_prom),
        .cfg_runt_ok(cfg_runt_ok), .cfg_no_phys(cfg_no_phys),
        .cfg_laf_zero(cfg_laf_zero), .dec_valid(dec_valid),
        .dec_accept(dec_accept)
    );

    always @(negedge clk) begin
        if (dec_valid) begin
            n_valid  = n_valid + 1;
            last_acc = dec_accept;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one frame: len bytes, low pulse on cycles [ls, ls+ll), match pulse at cycle 30,
    // optional stop of 'started' at cycle drop_at (negative: never).
    task automatic frame(input int len, input int ls, input int ll, input bit m, input int drop_at);
        @(negedge clk);
        n_valid = 0;
        sfd = 1'b1;
        @(negedge clk);
        sfd = 1'b0;
        for (int c = 0; c < len * BYTE_CYC; c++) begin
            byte_stb     = (c % BYTE_CYC) == BYTE_CYC - 1;
            int_match    = m && (c == 30);
            ext_reject_n = !(c >= ls && c < ls + ll);
            if (c == drop_at) started = 1'b0;
            @(negedge clk);
        end
        byte_stb = 1'b0; int_match = 1'b0; ext_reject_n = 1'b1;
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid in reset", dec_valid, 0);
        check("R10 accept in reset", dec_accept, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after reset", dec_valid, 0);

        // R1: not started, no decision
        frame(20, -100, 0, 1'b0, -1);
        check("R1 no decision while stopped", n_valid, 0);
        started = 1'b1;
        frame(90, -100, 0, 1'b0, 40);
        check("R1 no decision after stop mid-frame", n_valid, 0);
        started = 1'b1;

        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int m = 0; m < 2; m++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    for (int lsel = 0; lsel < 2; lsel++) begin
                        int len, ls, ll, exp_acc;
                        bit runt, eff_m, rej;
                        string tag;
                        cfg_prom     = cfg[0];
                        cfg_runt_ok  = cfg[1];
                        cfg_no_phys  = cfg[2];
                        cfg_laf_zero = cfg[3];
                        len  = lsel ? 90 : 20;
                        runt = len < WINDOW;
                        case (pat)
                            0: begin ls = -100; ll = 0; end
                            1: begin ls = 8; ll = MIN_LOW - 1; end
                            2: begin ls = 8; ll = MIN_LOW; end
                            default: begin ls = WINDOW * BYTE_CYC + 8; ll = MIN_LOW; end
                        endcase
                        eff_m = m[0] && !(cfg[2] && cfg[3]);
                        rej   = (pat == 2);
                        if (runt && !cfg[1]) exp_acc = 0;
                        else exp_acc = (cfg[0] || eff_m || !rej) ? 1 : 0;
                        if (runt && !cfg[1]) tag = "R8";
                        else if (cfg[0]) tag = "R4";
                        else if (eff_m) tag = "R3";
                        else if (m[0]) tag = "R9";
                        else if (pat == 1) tag = "R5";
                        else if (pat == 3 && !runt) tag = "R6";
                        else tag = "R7";
                        frame(len, ls, ll, m[0], -1);
                        check("R2 one decision per frame", n_valid, 1);
                        check(tag, last_acc, exp_acc);
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule